// File: doc/BRIEF.md
# DDR Read Capture and Half-Rate Widening Path

This block is the receive side of one data bit of a double-data-rate memory interface. It samples the incoming bit on both edges of the strobe and moves the falling-edge sample onto the rising edge, so both bits of a beat travel together as a pair. The pair then goes through a resynchronization chain clocked by the full-rate resync clock, with a selectable number of levels. A half-rate stage then gathers two consecutive pairs into a four-bit word that changes once every two resync cycles. A divide-by-two clock is driven out alongside the word.

Each stage can be bypassed on its own: the capture registers, the resync levels (depth zero), and the half-rate widening. A separate output-bypass select can be changed at run time. It routes the current resync pair straight onto the two even output lanes while the odd lanes keep showing the widened word. The falling-edge capture can take either the inverted strobe or a separate complementary strobe as its clock.

Top module: `ddr_rd_path`

## Requirements
- R1: With capture enabled, the rising-edge bit sampled at strobe edge k is presented as the pair's rise bit from just after edge k until edge k+1.
- R2: With capture enabled, the bit sampled on the falling edge that follows strobe edge k is presented as the pair's fall bit from just after strobe edge k+1. It therefore sits alongside the rise bit of edge k+1.
- R3: Choosing the separate complementary strobe (`neg_clk_sel`=1) as the falling-edge clock gives the same outputs as deriving it from the inverted strobe, when the complementary strobe is the inverse of the strobe.
- R4: With capture bypassed (`cap_bypass`=1), both bits of the pair are the live `dq` value.
- R5: `rsy_levels` = d (0 to 3) delays the pair by exactly d resync cycles. With d = 0 the pair passes through without a register.
- R6: With widening active, the word updates on every second resync edge, on those edges where `hr_clk` was 1 just before the edge. Bit 0 takes the older pair's rise bit, bit 1 its fall bit, bit 2 the newer pair's rise bit and bit 3 its fall bit. At all other edges the word holds.
- R7: `hr_clk` is 0 after the first resync edge following reset release, then inverts on every resync edge.
- R8: With widening bypassed (`hr_bypass`=1), `rdata[0]` shows the resync rise bit, `rdata[2]` shows the resync fall bit, and `rdata[1]` and `rdata[3]` are 0.
- R9: With `out_bypass`=1, which may change at any time, `rdata[0]` and `rdata[2]` show the resync rise and fall bits directly, while `rdata[1]` and `rdata[3]` continue to follow R6.
- R10: While `rst_n` is low, every register clears, so `rdata` is 0 and `hr_clk` is 0 (with `dq` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_stb | input | 1 | Strobe clock; rising edge captures and aligns |
| clk_stbn | input | 1 | Complementary strobe, used for falling-edge capture when selected |
| clk_rsy | input | 1 | Full-rate resynchronization clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously per domain |
| neg_clk_sel | input | 1 | Static: 1 selects clk_stbn for falling-edge capture, 0 uses inverted clk_stb |
| cap_bypass | input | 1 | Static: bypass the capture registers |
| rsy_levels | input | 2 | Static: number of resync register levels, 0 to 3 |
| hr_bypass | input | 1 | Static: bypass the half-rate widening stage |
| out_bypass | input | 1 | Run-time select: even lanes take the resync pair directly |
| dq | input | 1 | Serial data bit from the pad |
| rdata | output | 4 | Data toward the core, lane encoding per R6, R8 and R9 |
| hr_clk | output | 1 | Half-rate clock, the resync clock divided by two |

## Verification
The bench builds the block with its default parameters: three resync levels at most and a two-stage reset synchronizer. Because the depth, both bypasses and the falling-edge clock choice are inputs, that single build reaches all 32 static configurations, and the bench resets the block between them. In each configuration a random bit sequence is driven on both edges and the output lanes and `hr_clk` are compared against a behavioural model on every cycle. This pins down the exact latency for each depth, the pairing phase after reset, and the full-rate versus half-rate lane mapping. The run-time output bypass is toggled at random in mid-run, which shows the even lanes switching sources while the odd lanes keep their widened values.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  // One DDR beat: the bit taken on the rising strobe edge and the
  // aligned bit taken on the preceding falling edge.
  typedef struct packed {
    logic rise;
    logic fall;
  } ddr_pair_t;

  // Width of the half-rate word toward the core (two pairs).
  localparam int HR_W = 4;

endpackage

// File: rtl/ddr_rst_sync.sv
module ddr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/ddr_cap_stage.sv
module ddr_cap_stage
  import ddr_rd_pkg::*;
(
  input  logic      clk_pos,
  input  logic      clk_neg,
  input  logic      rst_n,
  input  logic      byp,
  input  logic      dq,
  output ddr_pair_t pair_o
);

  logic cap_en;
  logic pos_q, pos_d;
  logic neg_q, neg_d;
  logic al_q,  al_d;

  // Next-state: registers freeze while the stage is bypassed.
  always_comb begin
    cap_en = !byp;
    pos_d  = cap_en ? dq    : pos_q;
    neg_d  = cap_en ? dq    : neg_q;
    al_d   = cap_en ? neg_q : al_q;
  end

  always_ff @(posedge clk_pos or negedge rst_n) begin
    if (!rst_n) pos_q <= 1'b0;
    else        pos_q <= pos_d;
  end

  always_ff @(posedge clk_neg or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= neg_d;
  end

  // Alignment register shares the rising-edge clock.
  always_ff @(posedge clk_pos or negedge rst_n) begin
    if (!rst_n) al_q <= 1'b0;
    else        al_q <= al_d;
  end

  always_comb begin
    if (byp) begin
      pair_o.rise = dq;
      pair_o.fall = dq;
    end else begin
      pair_o.rise = pos_q;
      pair_o.fall = al_q;
    end
  end

endmodule

// File: rtl/ddr_rsy_chain.sv
module ddr_rsy_chain
  import ddr_rd_pkg::*;
#(
  parameter  int MAX_DEPTH = 3,
  localparam int SEL_W     = $clog2(MAX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] depth,
  input  ddr_pair_t        din,
  output ddr_pair_t        dout
);

  ddr_pair_t [MAX_DEPTH:0] tap;

  assign tap[0] = din;

  for (genvar g = 1; g <= MAX_DEPTH; g++) begin : g_lvl
    ddr_pair_t lvl_q, lvl_d;
    logic      lvl_en;

    // Levels beyond the selected depth are held still.
    always_comb begin
      lvl_en = (depth >= SEL_W'(g));
      lvl_d  = lvl_en ? tap[g-1] : lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= '0;
      else        lvl_q <= lvl_d;
    end

    assign tap[g] = lvl_q;
  end

  // Tap select; out-of-range codes fall back to the deepest level.
  always_comb begin
    dout = tap[MAX_DEPTH];
    for (int i = 0; i <= MAX_DEPTH; i++) begin
      if (depth == SEL_W'(i)) dout = tap[i];
    end
  end

endmodule

// File: rtl/ddr_hr_stage.sv
module ddr_hr_stage
  import ddr_rd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hr_byp,
  input  logic            out_byp,
  input  ddr_pair_t       din,
  output logic [HR_W-1:0] rdata,
  output logic            hr_clk
);

  logic            ph_q,   ph_d;
  ddr_pair_t       hold_q, hold_d;
  logic [HR_W-1:0] word_q, word_d;
  logic            hold_en, word_en;

  // Phase 0 edges park the older pair; phase 1 edges load the word.
  always_comb begin
    ph_d    = ~ph_q;
    hold_en = !ph_q;
    word_en = ph_q;
    hold_d  = hold_en ? din : hold_q;
    word_d  = word_en ? {din.fall, din.rise, hold_q.fall, hold_q.rise} : word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= 1'b0;
      hold_q <= '0;
      word_q <= '0;
    end else begin
      ph_q   <= ph_d;
      hold_q <= hold_d;
      word_q <= word_d;
    end
  end

  always_comb begin
    rdata[0] = (hr_byp || out_byp) ? din.rise : word_q[0];
    rdata[2] = (hr_byp || out_byp) ? din.fall : word_q[2];
    rdata[1] = hr_byp ? 1'b0 : word_q[1];
    rdata[3] = hr_byp ? 1'b0 : word_q[3];
  end

  assign hr_clk = ph_q;

endmodule

// File: rtl/ddr_rd_path.sv
module ddr_rd_path
  import ddr_rd_pkg::*;
#(
  parameter  int RSY_MAX     = 3,
  parameter  int SYNC_STAGES = 2,
  localparam int SEL_W       = $clog2(RSY_MAX + 1)
) (
  input  logic             clk_stb,
  input  logic             clk_stbn,
  input  logic             clk_rsy,
  input  logic             rst_n,
  input  logic             neg_clk_sel,
  input  logic             cap_bypass,
  input  logic [SEL_W-1:0] rsy_levels,
  input  logic             hr_bypass,
  input  logic             out_bypass,
  input  logic             dq,
  output logic [HR_W-1:0]  rdata,
  output logic             hr_clk
);

  logic      clk_neg;
  logic      stb_rst_n;
  logic      rsy_rst_n;
  ddr_pair_t cap_pair;
  ddr_pair_t rsy_pair;

  // Falling-edge capture clock: complementary strobe or inverted strobe.
  assign clk_neg = neg_clk_sel ? clk_stbn : ~clk_stb;

  ddr_rst_sync #(.STAGES(SYNC_STAGES)) u_stb_rst (
    .clk    (clk_stb),
    .arst_n (rst_n),
    .srst_n (stb_rst_n)
  );

  ddr_rst_sync #(.STAGES(SYNC_STAGES)) u_rsy_rst (
    .clk    (clk_rsy),
    .arst_n (rst_n),
    .srst_n (rsy_rst_n)
  );

  ddr_cap_stage u_cap (
    .clk_pos (clk_stb),
    .clk_neg (clk_neg),
    .rst_n   (stb_rst_n),
    .byp     (cap_bypass),
    .dq      (dq),
    .pair_o  (cap_pair)
  );

  ddr_rsy_chain #(.MAX_DEPTH(RSY_MAX)) u_rsy (
    .clk   (clk_rsy),
    .rst_n (rsy_rst_n),
    .depth (rsy_levels),
    .din   (cap_pair),
    .dout  (rsy_pair)
  );

  ddr_hr_stage u_hr (
    .clk     (clk_rsy),
    .rst_n   (rsy_rst_n),
    .hr_byp  (hr_bypass),
    .out_byp (out_bypass),
    .din     (rsy_pair),
    .rdata   (rdata),
    .hr_clk  (hr_clk)
  );

endmodule

// File: rtl/ddr_rd_path_chk.sv
module ddr_rd_path_chk #(
  parameter int SEL_W = 2
) (
  input logic             clk_rsy,
  input logic             rsy_rst_n,
  input logic             hr_bypass,
  input logic             hr_clk,
  input logic [SEL_W-1:0] rsy_levels,
  input logic [3:0]       rdata,
  input logic [1:0]       cap_pr,
  input logic [1:0]       rsy_pr
);

  // R7: divided clock alternates on every resync edge
  p_hrclk_rise_r7: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    !hr_clk |=> hr_clk);
  p_hrclk_fall_r7: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    hr_clk |=> !hr_clk);

  // R6: odd lanes hold across phase-0 edges
  p_word_hold_r6: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    (!hr_bypass && !hr_clk) |=> ($stable(rdata[1]) && $stable(rdata[3])));

  // R6: on a phase-1 edge the newer fall bit lands on lane 3, the older on lane 1
  p_word_load_r6: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    (!hr_bypass && hr_clk) |=>
      ((rdata[3] == $past(rsy_pr[0])) && (rdata[1] == $past(rsy_pr[0], 2))));

  // R5: latency through the resync levels
  p_lat1_r5: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    (rsy_levels == SEL_W'(1)) |=> (rsy_pr == $past(cap_pr)));
  p_lat2_r5: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    ((rsy_levels == SEL_W'(2)) && $past(rsy_rst_n)) |=> (rsy_pr == $past(cap_pr, 2)));
  p_lat3_r5: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    ((rsy_levels == SEL_W'(3)) && $past(rsy_rst_n, 2)) |=> (rsy_pr == $past(cap_pr, 3)));

  // R8: odd lanes silent while widening is bypassed
  p_hrbyp_zero_r8: assert property (@(posedge clk_rsy) disable iff (!rsy_rst_n)
    hr_bypass |-> (rdata[1] == 1'b0 && rdata[3] == 1'b0));

endmodule

bind ddr_rd_path ddr_rd_path_chk #(.SEL_W(SEL_W)) u_chk (
  .clk_rsy    (clk_rsy),
  .rsy_rst_n  (rsy_rst_n),
  .hr_bypass  (hr_bypass),
  .hr_clk     (hr_clk),
  .rsy_levels (rsy_levels),
  .rdata      (rdata),
  .cap_pr     (cap_pair),
  .rsy_pr     (rsy_pair)
);

// File: tb/ddr_rd_path_bench.sv
module ddr_rd_path_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NC = 44;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       clk_stbn;
  logic       rst_n, sep, cb, hb, ob, dq;
  logic [1:0] dep;
  logic [3:0] rdata;
  logic       hr_clk;

  assign clk_stbn = ~clk;

  ddr_rd_path u_ddr_rd_path (
    .clk_stb     (clk),
    .clk_stbn    (clk_stbn),
    .clk_rsy     (clk),
    .rst_n       (rst_n),
    .neg_clk_sel (sep),
    .cap_bypass  (cb),
    .rsy_levels  (dep),
    .hr_bypass   (hb),
    .out_bypass  (ob),
    .dq          (dq),
    .rdata       (rdata),
    .hr_clk      (hr_clk)
  );

  int total = 0;
  int bad   = 0;
  bit rb [NC+2];
  bit fb [NC+2];

  function automatic bit rv(int j);
    return (j < 0 || j >= NC + 2) ? 1'b0 : rb[j];
  endfunction

  function automatic bit fv(int j);
    return (j < 0 || j >= NC + 2) ? 1'b0 : fb[j];
  endfunction

  // Pair {rise,fall} presented to the first resync level just before edge e.
  function automatic logic [1:0] vpre(int e);
    if (cb) return {rv(e), rv(e)};
    return {rv(e - 1), fv(e - 2)};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Compare outputs seen just after resync edge n (n = 0 is the first edge
  // after the reset synchronizer lets go).
  task automatic compare(input int n);
    int          d;
    int          k;
    logic [1:0]  robs, nw, od;
    logic [3:0]  word, exp;
    string       ctag, etag, otag;
    d    = int'(dep);
    robs = (d == 0 && cb) ? vpre(n) : vpre(n + 1 - d);
    k    = n - (n % 2);
    word = 4'b0000;
    if (k >= 2) begin
      nw   = vpre(k - d);
      od   = vpre(k - 1 - d);
      word = {nw[0], nw[1], od[0], od[1]};
    end
    exp[0] = (hb || ob) ? robs[1] : word[0];
    exp[2] = (hb || ob) ? robs[0] : word[2];
    exp[1] = hb ? 1'b0 : word[1];
    exp[3] = hb ? 1'b0 : word[3];
    ctag = cb ? "R4" : "R1 R2";
    if (sep) ctag = {ctag, " R3"};
    etag = hb ? "R8" : (ob ? "R9" : "R6");
    otag = hb ? "R8" : (ob ? "R9 R6" : "R6");
    chk($sformatf("%s R5 %s even lanes d=%0d n=%0d", ctag, etag, d, n),
        {2'b00, rdata[2], rdata[0]}, {2'b00, exp[2], exp[0]});
    chk($sformatf("%s R5 %s odd lanes d=%0d n=%0d", ctag, otag, d, n),
        {2'b00, rdata[3], rdata[1]}, {2'b00, exp[3], exp[1]});
    chk($sformatf("R7 hr_clk n=%0d", n), {3'b000, hr_clk}, {3'b000, 1'(n % 2)});
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(5ns * 20000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    dq    = 1'b0;
    ob    = 1'b0;
    {sep, cb, hb, dep} = 5'd0;
    for (int cfg = 0; cfg < 32; cfg++) begin
      rst_n = 1'b0;
      dq    = 1'b0;
      ob    = 1'b0;
      {sep, cb, hb, dep} = cfg[4:0];
      for (int j = 0; j < NC + 2; j++) begin
        rb[j] = (j < 2) ? 1'b0 : 1'($urandom_range(0, 1));
        fb[j] = (j < 2) ? 1'b0 : 1'($urandom_range(0, 1));
      end
      repeat (2) @(posedge clk);
      #1;
      // R10: cleared outputs under reset
      chk($sformatf("R10 reset rdata cfg=%0d", cfg), rdata, 4'b0000);
      chk($sformatf("R10 reset hr_clk cfg=%0d", cfg), {3'b000, hr_clk}, 4'b0000);
      @(posedge clk);
      #1.25 rst_n = 1'b1;
      @(posedge clk);
      for (int j = 0; j < NC; j++) begin
        @(posedge clk);
        #0.5 compare(j);
        #0.75 dq = fb[j];
        #1.5 if (j >= 4) ob = ($urandom_range(0, 2) == 0);
        #1 dq = rb[j + 1];
      end
    end
    summary();
    $finish;
  end

endmodule